// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the internal control registers that privileged firmware reads and writes by a six-bit index. It is not a uniform array. Each index has its own rule. Some registers take a full 64-bit write. Some keep only a masked subset of bits. Some clear on any write. Some can only be read and others can only be written. Some exist only to send a one-cycle invalidate command to the instruction or data translation buffer.

There is one access port: `idx`, with `rd_en` or `wr_en`. Read data is combinational and valid in the same cycle as the access. A write commits at the clock edge. One cycle after an access edge, the block reports an illegal access on `acc_err` and drives its invalidate strobes.

Two read values are built rather than stored:
- The cycle-count read joins the stored upper word with a free-running 32-bit counter.
- The data page-table-entry read packs fields supplied by the translation buffer.

Top module: `pcr_bank`

## Requirements
- R1: After reset every register reads zero, with three exceptions. Index 0x18 reads parameter FW_BASE. Index 0x19 reads 0x6. Index 0x10 (scratch 16) reads parameter CPU_ID.
- R2: Indices 0x00–0x17 (scratch), 0x18 and 0x19 store and read back all 64 written bits.
- R3: A write keeps only the masked bits, as follows:
  - 0x1A and 0x1B keep 0xF.
  - 0x1C keeps 0x1F.
  - 0x1D keeps 0x18.
  - 0x1E keeps 0x7FFF0.
  - 0x1F keeps 0xFF_FFFF_0300.
  - 0x20 keeps bits [63:30].
  - 0x25 and 0x26 keep 0x3F.
  - 0x27 keeps 0x7F0.
  - 0x28 keeps bits [63:57].
- R4: A write to 0x21 stores the value with bit 1 forced to zero.
- R5: A write of any value to 0x22 or 0x23 leaves that register at zero.
- R6: A read of 0x24 returns the written bits [63:32] above a 32-bit counter in bits [31:0]. The counter advances by one every clock.
- R7: A read of 0x29 returns the translation-buffer fields ORed together at these positions:
  - ppn[26:0] at [58:32]
  - read-enable[3:0] at [11:8]
  - write-enable[3:0] at [15:12]
  - fault-on-read at bit 1
  - fault-on-write at bit 2
  - address-match at bit 4
  - asn[6:0] at [63:57]
- R8: A read of a write-only index (0x30–0x3A) pulses `acc_err`.
- R9: A write to a read-only index (0x2A–0x2E) pulses `acc_err` and leaves the register reading zero.
- R10: Any access to an undefined index (0x2F, 0x3B–0x3F) pulses `acc_err`.
- R11: A write to one of the following gives a one-cycle pulse on the matching strobe in the cycle after the write edge:
  - 0x35 or 0x36 drives data invalidate-all or invalidate-process.
  - 0x38 or 0x39 drives instruction invalidate-all or invalidate-process.
- R12: A write to 0x37 or 0x3A pulses the data or instruction invalidate-one strobe. `inv_va` carries the written address. `inv_asn` carries the data ASN (0x28 bits [63:57]) or the instruction ASN (0x27 bits [10:4]).
- R13: `acc_err` is high only in the single cycle after an illegal access edge, and stays low after legal accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx | input | 6 | Register index |
| rd_en | input | 1 | Read access |
| wr_en | input | 1 | Write access |
| wr_data | input | 64 | Write value |
| rd_data | output | 64 | Combinational read value |
| acc_err | output | 1 | Illegal-access pulse |
| pte_ppn | input | 27 | Translation-buffer physical page number |
| pte_rd_en | input | 4 | Per-mode read enables |
| pte_wr_en | input | 4 | Per-mode write enables |
| pte_fault_rd | input | 1 | Fault-on-read |
| pte_fault_wr | input | 1 | Fault-on-write |
| pte_asm | input | 1 | Address-space match |
| pte_asn | input | 7 | Entry ASN |
| dtb_inv_all | output | 1 | Data TB invalidate-all strobe |
| dtb_inv_proc | output | 1 | Data TB invalidate-process strobe |
| dtb_inv_one | output | 1 | Data TB invalidate-one strobe |
| itb_inv_all | output | 1 | Instruction TB invalidate-all strobe |
| itb_inv_proc | output | 1 | Instruction TB invalidate-process strobe |
| itb_inv_one | output | 1 | Instruction TB invalidate-one strobe |
| inv_va | output | 64 | Address for an invalidate-one |
| inv_asn | output | 7 | ASN for an invalidate-one |

## Verification
The hardest case to reach is the ASN that travels with an invalidate-one strobe. That ASN comes from a masked register written earlier, so it can only be observed by a sequence of two writes. The stimulus first writes the ASN register with extra bits outside its mask. It then writes the invalidate-one index and samples `inv_asn` in the following cycle. This checks both the mask and the field extraction. The free-running counter is another case the ports cannot preset. It is checked by reading the cycle register twice, a known number of cycles apart, and comparing the difference.

// File: rtl/pcr_bank.sv
module pcr_bank #(
  parameter logic [63:0] FW_BASE = 64'h0000_0000_0000_8000,
  parameter logic [63:0] CPU_ID  = 64'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  idx,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  output logic [63:0] rd_data,
  output logic        acc_err,
  input  logic [26:0] pte_ppn,
  input  logic [3:0]  pte_rd_en,
  input  logic [3:0]  pte_wr_en,
  input  logic        pte_fault_rd,
  input  logic        pte_fault_wr,
  input  logic        pte_asm,
  input  logic [6:0]  pte_asn,
  output logic        dtb_inv_all,
  output logic        dtb_inv_proc,
  output logic        dtb_inv_one,
  output logic        itb_inv_all,
  output logic        itb_inv_proc,
  output logic        itb_inv_one,
  output logic [63:0] inv_va,
  output logic [6:0]  inv_asn
);
  localparam logic [5:0] I_SCR16  = 6'h10;
  localparam logic [5:0] I_FWBASE = 6'h18;
  localparam logic [5:0] I_MISC   = 6'h19;
  localparam logic [5:0] I_ASTR   = 6'h1A;
  localparam logic [5:0] I_ASTE   = 6'h1B;
  localparam logic [5:0] I_IPL    = 6'h1C;
  localparam logic [5:0] I_IMODE  = 6'h1D;
  localparam logic [5:0] I_SWIRQ  = 6'h1E;
  localparam logic [5:0] I_ICSR   = 6'h1F;
  localparam logic [5:0] I_PTBR   = 6'h20;
  localparam logic [5:0] I_EXADR  = 6'h21;
  localparam logic [5:0] I_EXSUM  = 6'h22;
  localparam logic [5:0] I_EXMSK  = 6'h23;
  localparam logic [5:0] I_CYC    = 6'h24;
  localparam logic [5:0] I_DCMODE = 6'h25;
  localparam logic [5:0] I_MAFMD  = 6'h26;
  localparam logic [5:0] I_IASN   = 6'h27;
  localparam logic [5:0] I_DASN   = 6'h28;
  localparam logic [5:0] I_DPTE   = 6'h29;
  localparam logic [5:0] I_RO_LO  = 6'h2A;
  localparam logic [5:0] I_RO_HI  = 6'h2E;
  localparam logic [5:0] I_WO_LO  = 6'h30;
  localparam logic [5:0] I_DIA    = 6'h35;
  localparam logic [5:0] I_DIP    = 6'h36;
  localparam logic [5:0] I_DIS    = 6'h37;
  localparam logic [5:0] I_IIA    = 6'h38;
  localparam logic [5:0] I_IIP    = 6'h39;
  localparam logic [5:0] I_IIS    = 6'h3A;
  localparam int         NST      = 41;

  logic [63:0] regs_q [NST];
  logic [31:0] cnt_q;

  function automatic logic [63:0] wmask(input logic [5:0] i);
    case (i)
      I_ASTR, I_ASTE:    wmask = 64'hF;
      I_IPL:             wmask = 64'h1F;
      I_IMODE:           wmask = 64'h18;
      I_SWIRQ:           wmask = 64'h7_FFF0;
      I_ICSR:            wmask = 64'hFF_FFFF_0300;
      I_PTBR:            wmask = {34'h3_FFFF_FFFF, 30'h0};
      I_EXADR:           wmask = ~64'h2;
      I_EXSUM, I_EXMSK:  wmask = 64'h0;
      I_DCMODE, I_MAFMD: wmask = 64'h3F;
      I_IASN:            wmask = 64'h7F0;
      I_DASN:            wmask = {7'h7F, 57'h0};
      default:           wmask = '1;
    endcase
  endfunction

  function automatic logic [63:0] rst_val(input int i);
    if (i == int'(I_FWBASE))     rst_val = FW_BASE;
    else if (i == int'(I_MISC))  rst_val = 64'h6;
    else if (i == int'(I_SCR16)) rst_val = CPU_ID;
    else                         rst_val = 64'h0;
  endfunction

  wire rd_ok = (idx <= I_DPTE) || (idx >= I_RO_LO && idx <= I_RO_HI);
  wire wr_ok = (idx <= I_DPTE) || (idx >= I_WO_LO && idx <= I_IIS);
  wire st_wr = wr_en && (idx < I_DPTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) regs_q[i] <= rst_val(i);
    end else if (st_wr) begin
      regs_q[idx] <= wr_data & wmask(idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 32'd1;
  end

  wire [63:0] pte_pack = ({37'h0, pte_ppn} << 32) | ({57'h0, pte_asn} << 57)
                       | {48'h0, pte_wr_en, pte_rd_en, 3'b0, pte_asm, 1'b0,
                          pte_fault_wr, pte_fault_rd, 1'b0};

  always_comb begin
    if (idx == I_CYC)      rd_data = {regs_q[I_CYC][63:32], cnt_q};
    else if (idx == I_DPTE) rd_data = pte_pack;
    else if (idx < I_DPTE)  rd_data = regs_q[idx];
    else                    rd_data = 64'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_err      <= 1'b0;
      dtb_inv_all  <= 1'b0;
      dtb_inv_proc <= 1'b0;
      dtb_inv_one  <= 1'b0;
      itb_inv_all  <= 1'b0;
      itb_inv_proc <= 1'b0;
      itb_inv_one  <= 1'b0;
      inv_va       <= '0;
      inv_asn      <= '0;
    end else begin
      acc_err      <= (rd_en && !rd_ok) || (wr_en && !wr_ok);
      dtb_inv_all  <= wr_en && idx == I_DIA;
      dtb_inv_proc <= wr_en && idx == I_DIP;
      dtb_inv_one  <= wr_en && idx == I_DIS;
      itb_inv_all  <= wr_en && idx == I_IIA;
      itb_inv_proc <= wr_en && idx == I_IIP;
      itb_inv_one  <= wr_en && idx == I_IIS;
      if (wr_en && idx == I_DIS) begin
        inv_va  <= wr_data;
        inv_asn <= regs_q[I_DASN][63:57];
      end else if (wr_en && idx == I_IIS) begin
        inv_va  <= wr_data;
        inv_asn <= regs_q[I_IASN][10:4];
      end
    end
  end
endmodule

// File: rtl/pcr_bank_chk.sv
module pcr_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  idx,
  input logic        rd_en,
  input logic        wr_en,
  input logic [63:0] wr_data,
  input logic [63:0] rd_data,
  input logic        acc_err,
  input logic        dtb_inv_all,
  input logic        dtb_inv_proc,
  input logic        dtb_inv_one,
  input logic        itb_inv_all,
  input logic        itb_inv_proc,
  input logic        itb_inv_one,
  input logic [63:0] inv_va
);
  p_wo_read_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx >= 6'h30 && idx <= 6'h3A) |=> acc_err);

  p_ro_write_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx >= 6'h2A && idx <= 6'h2E) |=> acc_err);

  p_undef_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && idx >= 6'h3B) |=> acc_err);

  p_idle_no_err_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> !acc_err);

  p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dtb_inv_all, dtb_inv_proc, dtb_inv_one, itb_inv_all, itb_inv_proc, itb_inv_one}));

  p_inv_one_va_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 6'h37) |=> (dtb_inv_one && inv_va == $past(wr_data)));

  p_ipl_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == 6'h1C) |-> rd_data[63:5] == '0);

  p_exc_addr_bit1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == 6'h21) |-> !rd_data[1]);

  p_exc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (idx == 6'h22 || idx == 6'h23)) |-> rd_data == 64'h0);
endmodule

bind pcr_bank pcr_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idx(idx), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .acc_err(acc_err),
  .dtb_inv_all(dtb_inv_all), .dtb_inv_proc(dtb_inv_proc), .dtb_inv_one(dtb_inv_one),
  .itb_inv_all(itb_inv_all), .itb_inv_proc(itb_inv_proc), .itb_inv_one(itb_inv_one),
  .inv_va(inv_va)
);

// File: tb/sim_pcr_bank.sv
module sim_pcr_bank;
  localparam time PERIOD = 10ns;
  localparam logic [63:0] FWB = 64'h0000_0000_0001_C000;
  localparam logic [63:0] CID = 64'h5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] idx = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic acc_err;
  logic [26:0] pte_ppn = '0;
  logic [3:0] pte_rd_en = '0, pte_wr_en = '0;
  logic pte_fault_rd = 1'b0, pte_fault_wr = 1'b0, pte_asm = 1'b0;
  logic [6:0] pte_asn = '0;
  logic dtb_inv_all, dtb_inv_proc, dtb_inv_one, itb_inv_all, itb_inv_proc, itb_inv_one;
  logic [63:0] inv_va;
  logic [6:0] inv_asn;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pcr_bank #(.FW_BASE(FWB), .CPU_ID(CID)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_rd(input logic [5:0] a, output logic [63:0] d, output logic e);
    @(negedge clk); idx = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
    #1 e = acc_err;
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [63:0] v, output logic e);
    @(negedge clk); idx = a; wr_data = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    #1 e = acc_err;
  endtask

  task automatic t_reset_r1;
    logic [63:0] d; logic e;
    do_rd(6'h18, d, e); chk("R1 fw base", d, FWB); chk("R13 legal read err", {63'h0, e}, 64'h0);
    do_rd(6'h19, d, e); chk("R1 misc ctl", d, 64'h6);
    do_rd(6'h10, d, e); chk("R1 scratch16", d, CID);
    do_rd(6'h00, d, e); chk("R1 scratch0", d, 64'h0);
    do_rd(6'h1F, d, e); chk("R1 icsr", d, 64'h0);
  endtask

  task automatic t_full_r2;
    logic [63:0] d; logic e;
    do_wr(6'h03, 64'hDEAD_BEEF_0123_4567, e); chk("R2 write err", {63'h0, e}, 64'h0);
    do_rd(6'h03, d, e); chk("R2 scratch3", d, 64'hDEAD_BEEF_0123_4567);
    do_wr(6'h19, 64'hFFFF_0000_FFFF_0000, e);
    do_rd(6'h19, d, e); chk("R2 misc", d, 64'hFFFF_0000_FFFF_0000);
  endtask

  task automatic t_masks_r3;
    logic [63:0] d; logic e;
    logic [63:0] ones = '1;
    do_wr(6'h1A, ones, e); do_rd(6'h1A, d, e); chk("R3 ast req", d, 64'hF);
    do_wr(6'h1C, ones, e); do_rd(6'h1C, d, e); chk("R3 ipl", d, 64'h1F);
    do_wr(6'h1D, ones, e); do_rd(6'h1D, d, e); chk("R3 imode", d, 64'h18);
    do_wr(6'h1E, ones, e); do_rd(6'h1E, d, e); chk("R3 swirq", d, 64'h7FFF0);
    do_wr(6'h1F, ones, e); do_rd(6'h1F, d, e); chk("R3 icsr", d, 64'hFF_FFFF_0300);
    do_wr(6'h20, ones, e); do_rd(6'h20, d, e); chk("R3 ptbr", d, 64'hFFFF_FFFF_C000_0000);
    do_wr(6'h26, ones, e); do_rd(6'h26, d, e); chk("R3 maf mode", d, 64'h3F);
    do_wr(6'h27, ones, e); do_rd(6'h27, d, e); chk("R3 iasn", d, 64'h7F0);
    do_wr(6'h28, ones, e); do_rd(6'h28, d, e); chk("R3 dasn", d, 64'hFE00_0000_0000_0000);
  endtask

  task automatic t_excaddr_r4;
    logic [63:0] d; logic e;
    do_wr(6'h21, 64'h1234_5678_9ABC_DEF7, e); do_rd(6'h21, d, e);
    chk("R4 exc addr", d, 64'h1234_5678_9ABC_DEF5);
  endtask

  task automatic t_excclr_r5;
    logic [63:0] d; logic e;
    do_wr(6'h22, 64'hFFFF_FFFF_FFFF_FFFF, e); do_rd(6'h22, d, e); chk("R5 exc sum", d, 64'h0);
    do_wr(6'h23, 64'h5555, e); do_rd(6'h23, d, e); chk("R5 exc mask", d, 64'h0);
  endtask

  task automatic t_cyc_r6;
    logic [63:0] d1, d2; logic e;
    do_wr(6'h24, 64'hABCD_1234_FFFF_FFFF, e);
    do_rd(6'h24, d1, e);
    do_rd(6'h24, d2, e);
    chk("R6 cyc upper", {32'h0, d1[63:32]}, 64'hABCD_1234);
    chk("R6 cyc advance", {32'h0, d2[31:0] - d1[31:0]}, 64'd2);
  endtask

  task automatic t_pte_r7;
    logic [63:0] d, exp; logic e;
    pte_ppn = 27'h5A5_A5A5; pte_rd_en = 4'h9; pte_wr_en = 4'h6;
    pte_fault_rd = 1'b1; pte_fault_wr = 1'b0; pte_asm = 1'b1; pte_asn = 7'h55;
    exp = (64'(pte_ppn) << 32) | (64'(pte_rd_en) << 8) | (64'(pte_wr_en) << 12)
        | (64'(pte_fault_rd) << 1) | (64'(pte_fault_wr) << 2) | (64'(pte_asm) << 4)
        | (64'(pte_asn) << 57);
    do_rd(6'h29, d, e); chk("R7 pte pack", d, exp);
    pte_fault_rd = 1'b0; pte_fault_wr = 1'b1; pte_asm = 1'b0; pte_asn = 7'h00;
    exp = (64'(pte_ppn) << 32) | (64'(pte_rd_en) << 8) | (64'(pte_wr_en) << 12) | 64'h4;
    do_rd(6'h29, d, e); chk("R7 pte pack fow", d, exp);
  endtask

  task automatic t_wo_r8;
    logic [63:0] d; logic e;
    do_rd(6'h30, d, e); chk("R8 alt mode read err", {63'h0, e}, 64'h1);
    do_rd(6'h37, d, e); chk("R8 inv one read err", {63'h0, e}, 64'h1);
  endtask

  task automatic t_ro_r9;
    logic [63:0] d; logic e;
    do_wr(6'h2C, 64'h1111, e); chk("R9 ro write err", {63'h0, e}, 64'h1);
    do_rd(6'h2C, d, e); chk("R9 ro unchanged", d, 64'h0); chk("R9 ro read ok", {63'h0, e}, 64'h0);
  endtask

  task automatic t_undef_r10;
    logic [63:0] d; logic e;
    do_rd(6'h2F, d, e); chk("R10 undef read", {63'h0, e}, 64'h1);
    do_wr(6'h3F, 64'h1, e); chk("R10 undef write", {63'h0, e}, 64'h1);
  endtask

  task automatic t_err_pulse_r13;
    logic [63:0] d; logic e;
    do_rd(6'h3C, d, e); chk("R13 err set", {63'h0, e}, 64'h1);
    @(negedge clk); #1 chk("R13 err one cycle", {63'h0, acc_err}, 64'h0);
  endtask

  task automatic t_inv_bulk_r11;
    logic e;
    do_wr(6'h35, 64'h77, e);
    chk("R11 dtb all", {58'h0, dtb_inv_all, dtb_inv_proc, dtb_inv_one, itb_inv_all, itb_inv_proc, itb_inv_one}, 64'h20);
    @(negedge clk); #1 chk("R11 dtb all pulse", {63'h0, dtb_inv_all}, 64'h0);
    do_wr(6'h39, 64'h0, e);
    chk("R11 itb proc", {58'h0, dtb_inv_all, dtb_inv_proc, dtb_inv_one, itb_inv_all, itb_inv_proc, itb_inv_one}, 64'h02);
  endtask

  task automatic t_inv_one_r12;
    logic e;
    do_wr(6'h28, 64'h5400_0000_0000_00FF, e);
    do_wr(6'h37, 64'h0000_1234_5678_A000, e);
    chk("R12 dtb one", {63'h0, dtb_inv_one}, 64'h1);
    chk("R12 dtb va", inv_va, 64'h0000_1234_5678_A000);
    chk("R12 dtb asn", {57'h0, inv_asn}, 64'h2A);
    do_wr(6'h27, 64'hFFFF_FFFF_FFFF_F5A5, e);
    do_wr(6'h3A, 64'h0000_00FF_0000_2000, e);
    chk("R12 itb one", {63'h0, itb_inv_one}, 64'h1);
    chk("R12 itb va", inv_va, 64'h0000_00FF_0000_2000);
    chk("R12 itb asn", {57'h0, inv_asn}, 64'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R13 reset err low", {63'h0, acc_err}, 64'h0);
    t_reset_r1;
    t_full_r2;
    t_masks_r3;
    t_excaddr_r4;
    t_excclr_r5;
    t_cyc_r6;
    t_pte_r7;
    t_wo_r8;
    t_ro_r9;
    t_undef_r10;
    t_err_pulse_r13;
    t_inv_bulk_r11;
    t_inv_one_r12;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule